// File: doc/BRIEF.md
# Multi-level interrupt priority arbiter

The block collects interrupt requests from many sources into eight priority levels. Each level holds a word of request bits. A source posts a request by pulsing its level's set strobe together with a bit mask. From these words, the current processor priority and a bus-mode input, the block computes one combinational flag. The flag says whether any request may preempt the processor.

When the processor pulses acknowledge, the block names the winning request as a level number and a bit index in that same cycle, and it clears that bit at the clock edge. The level/bit pair is meant to index a vector table that sits outside the block.

In single-level-bus mode, device requests are hidden while the processor priority is 4 or higher. In that state only each level's internal sources can win. Those are the software request at bit 0 and, at level 6 only, the clock at bit 1.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every request word. After reset irq_pend is low and an acknowledge returns ack_valid low.
- R2: While set_stb[L] is high at a clock edge, the bits of set_mask[L*32 +: 32] are ORed into level L's request word. Bits already set stay set, and pulses to the same level accumulate.
- R3: Only a level strictly greater than cur_pri can be pending or win. A request at a level equal to or below cur_pri is not reported.
- R4: Among eligible levels, the highest-numbered level that has a nonzero word wins.
- R5: Within the winning level, the lowest-numbered set bit wins. Its index is given on ack_bit.
- R6: With single_bus high and cur_pri >= 4, each word is masked to its internal set before evaluation. The internal set is bit 0 at levels 1 to 7, plus bit 1 at level 6. Level 0 has an empty internal set.
- R7: With single_bus low, or with cur_pri < 4, every request bit takes part in evaluation.
- R8: In a cycle with ack high and a winner present, ack_valid is high, ack_lvl and ack_bit name the winner, and that single bit is clear from the next cycle on.
- R9: When ack is high and no request is eligible, ack_valid stays low and no request word changes. When ack is low, ack_valid is low.
- R10: If a set and an acknowledge-clear hit the same bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 8 | Per-level set strobe |
| set_mask | input | 256 | Per-level set bits; level L is at [L*32 +: 32] |
| cur_pri | input | 3 | Current processor priority |
| single_bus | input | 1 | High selects single-level-bus masking |
| ack | input | 1 | Acknowledge pulse |
| irq_pend | output | 1 | A request may preempt the processor |
| ack_valid | output | 1 | Acknowledge found a winner |
| ack_lvl | output | 3 | Winning level |
| ack_bit | output | 5 | Winning bit index within the level |

## Verification
The bench places requests exactly at the priority level to check the strict comparison; a design using greater-or-equal would report a request that must stay hidden. It puts device bits above internal ones under single-bus masking, at both priority 3 and priority 4. A wrong threshold or a wrong level-6 mask would pick the device bit, or would miss the clock bit. It also acknowledges an empty set and raises a set on the bit being cleared. A design that cleared anyway would lose the request, and one that changed state on an empty acknowledge would drop the hidden request that is later revealed.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int NUM_LEVELS   = 8;
   localparam int WORD_BITS    = 32;
   localparam int DEV_MIN_LVL  = 4;
   localparam int TICK_LVL     = 6;
   localparam int TICK_BIT     = 1;
endpackage

// File: rtl/irq_word_reg.sv
module irq_word_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         set_en,
   input  logic [W-1:0] set_bits,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] q
);
   logic [W-1:0] add_bits;
   assign add_bits = set_en ? set_bits : '0;

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= (q & ~clr_bits) | add_bits;
   end

   p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
      set_en |=> ((q & $past(set_bits)) == $past(set_bits)));
   p_clear_lands_r8: assert property (@(posedge clk) disable iff (rst)
      (|(clr_bits & ~add_bits)) |=> ((q & $past(clr_bits & ~add_bits)) == '0));
   p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
      (set_en && (|(set_bits & clr_bits))) |=>
      ((q & $past(set_bits & clr_bits)) == $past(set_bits & clr_bits)));
endmodule

// File: rtl/irq_lvl_filter.sv
module irq_lvl_filter #(
   parameter int W        = 32,
   parameter int LVL      = 0,
   parameter int TICK_LVL = 6,
   parameter int TICK_BIT = 1
) (
   input  logic [W-1:0] req,
   input  logic         restrict_en,
   output logic [W-1:0] eff
);
   logic [W-1:0] inner;
   generate
      if (LVL == 0) begin : g_none
         assign inner = '0;
      end else if (LVL == TICK_LVL) begin : g_tick
         assign inner = W'(1) | (W'(1) << TICK_BIT);
      end else begin : g_soft
         assign inner = W'(1);
      end
   endgenerate
   assign eff = restrict_en ? (req & inner) : req;
endmodule

// File: rtl/irq_first_bit.sv
module irq_first_bit #(
   parameter int W  = 32,
   parameter int IW = 5
) (
   input  logic [W-1:0]  word,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = |word;
      idx = '0;
      for (int i = W - 1; i >= 0; i--)
         if (word[i]) idx = IW'(i);
   end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
   import prio_irq_pkg::*;
#(
   parameter int N_LVL    = NUM_LEVELS,
   parameter int REQ_W    = WORD_BITS,
   parameter int IO_MIN   = DEV_MIN_LVL,
   parameter int CLK_LVL  = TICK_LVL,
   parameter int CLK_BIT  = TICK_BIT,
   localparam int LVL_W   = $clog2(N_LVL),
   localparam int BIT_W   = $clog2(REQ_W)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [N_LVL-1:0]       set_stb,
   input  logic [N_LVL*REQ_W-1:0] set_mask,
   input  logic [LVL_W-1:0]       cur_pri,
   input  logic                   single_bus,
   input  logic                   ack,
   output logic                   irq_pend,
   output logic                   ack_valid,
   output logic [LVL_W-1:0]       ack_lvl,
   output logic [BIT_W-1:0]       ack_bit
);
   generate
      if (REQ_W < 2 || (1 << BIT_W) != REQ_W) begin : g_bad_w
         $error("REQ_W must be a power of two of at least 2");
      end
      if (N_LVL < 2 || (1 << LVL_W) != N_LVL) begin : g_bad_l
         $error("N_LVL must be a power of two of at least 2");
      end
      if (CLK_BIT >= REQ_W || CLK_LVL >= N_LVL || IO_MIN >= N_LVL) begin : g_bad_p
         $error("clock position or device level out of range");
      end
   endgenerate

   logic             restrict_en;
   logic [REQ_W-1:0] word  [N_LVL];
   logic [REQ_W-1:0] eff   [N_LVL];
   logic [REQ_W-1:0] clr   [N_LVL];
   logic [N_LVL-1:0] lvl_any;
   logic [BIT_W-1:0] lvl_idx [N_LVL];
   logic             hit;
   logic [LVL_W-1:0] sel_lvl;

   assign restrict_en = single_bus && (cur_pri >= LVL_W'(IO_MIN));

   genvar g;
   generate
      for (g = 0; g < N_LVL; g++) begin : g_lvl
         assign clr[g] = (ack_valid && sel_lvl == LVL_W'(g))
                         ? (REQ_W'(1) << ack_bit) : '0;
         irq_word_reg #(.W(REQ_W)) u_reg (
            .clk(clk), .rst(rst), .set_en(set_stb[g]),
            .set_bits(set_mask[g*REQ_W +: REQ_W]), .clr_bits(clr[g]),
            .q(word[g]));
         irq_lvl_filter #(.W(REQ_W), .LVL(g), .TICK_LVL(CLK_LVL),
                          .TICK_BIT(CLK_BIT)) u_flt (
            .req(word[g]), .restrict_en(restrict_en), .eff(eff[g]));
         irq_first_bit #(.W(REQ_W), .IW(BIT_W)) u_pick (
            .word(eff[g]), .any(lvl_any[g]), .idx(lvl_idx[g]));
      end
   endgenerate

   always_comb begin
      hit     = 1'b0;
      sel_lvl = '0;
      for (int l = N_LVL - 1; l >= 0; l--) begin
         if (!hit && lvl_any[l] && (l > int'(cur_pri))) begin
            hit     = 1'b1;
            sel_lvl = LVL_W'(l);
         end
      end
   end

   assign irq_pend  = hit;
   assign ack_valid = ack && hit;
   assign ack_lvl   = sel_lvl;
   assign ack_bit   = lvl_idx[sel_lvl];

   p_above_pri_r3: assert property (@(posedge clk) disable iff (rst)
      ack_valid |-> (ack_lvl > cur_pri));
   p_internal_only_r6: assert property (@(posedge clk) disable iff (rst)
      (ack_valid && single_bus && cur_pri >= LVL_W'(IO_MIN)) |->
      (ack_bit == '0 || (ack_lvl == LVL_W'(CLK_LVL) && ack_bit == BIT_W'(CLK_BIT))));
   p_idle_ack_r9: assert property (@(posedge clk) disable iff (rst)
      !ack |-> !ack_valid);
endmodule

// File: tb/prio_irq_arbiter_test.sv
module prio_irq_arbiter_test;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [7:0]   set_stb = '0;
   logic [255:0] set_mask = '0;
   logic [2:0]   cur_pri = '0;
   logic         single_bus = 1'b0;
   logic         ack = 1'b0;
   logic         irq_pend, ack_valid;
   logic [2:0]   ack_lvl;
   logic [4:0]   ack_bit;
   int           n_run = 0;
   int           n_bad = 0;

   always #10 clk = ~clk;

   prio_irq_arbiter uut (
      .clk(clk), .rst(rst), .set_stb(set_stb), .set_mask(set_mask),
      .cur_pri(cur_pri), .single_bus(single_bus), .ack(ack),
      .irq_pend(irq_pend), .ack_valid(ack_valid), .ack_lvl(ack_lvl),
      .ack_bit(ack_bit));

   typedef struct packed {
      logic [2:0]  la;  logic [31:0] ma;
      logic [2:0]  lb;  logic [31:0] mb;
      logic [2:0]  pri; logic        sb;
      logic        pend;
      logic [2:0]  el;  logic [4:0]  eb;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VT [NV] = '{
      '{3'd5, 32'h10, 3'd2, 32'h4,        3'd0, 1'b0, 1'b1, 3'd5, 5'd4},  // R4
      '{3'd5, 32'h10, 3'd7, 32'h100,      3'd0, 1'b0, 1'b1, 3'd7, 5'd8},  // R4
      '{3'd5, 32'h10, 3'd5, 32'h8,        3'd0, 1'b0, 1'b1, 3'd5, 5'd3},  // R2 R5
      '{3'd4, 32'h10, 3'd3, 32'h2,        3'd4, 1'b0, 1'b0, 3'd0, 5'd0},  // R3
      '{3'd4, 32'h10, 3'd3, 32'h2,        3'd3, 1'b0, 1'b1, 3'd4, 5'd4},  // R3
      '{3'd6, 32'h4,  3'd5, 32'h2,        3'd4, 1'b1, 1'b0, 3'd0, 5'd0},  // R6
      '{3'd6, 32'h6,  3'd5, 32'h1,        3'd4, 1'b1, 1'b1, 3'd6, 5'd1},  // R6
      '{3'd7, 32'h2,  3'd5, 32'h1,        3'd4, 1'b1, 1'b1, 3'd5, 5'd0},  // R6
      '{3'd6, 32'h4,  3'd5, 32'h2,        3'd3, 1'b1, 1'b1, 3'd6, 5'd2},  // R7
      '{3'd6, 32'h4,  3'd7, 32'h80000000, 3'd5, 1'b0, 1'b1, 3'd7, 5'd31}, // R7
      '{3'd7, 32'h1,  3'd6, 32'h1,        3'd6, 1'b1, 1'b1, 3'd7, 5'd0}   // R6
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; set_stb = '0; ack = 1'b0;
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic post(input int l, input logic [31:0] m);
      set_stb = '0; set_mask = '0;
      set_stb[l] = 1'b1; set_mask[l*32 +: 32] = m;
      @(negedge clk);
      set_stb = '0; set_mask = '0;
   endtask

   task automatic try_ack(input string tag, input logic v, input logic [2:0] l, input logic [4:0] b);
      ack = 1'b1; #2;
      check({tag, " ack_valid"}, 32'(ack_valid), 32'(v));
      if (v) begin
         check({tag, " ack_lvl"}, 32'(ack_lvl), 32'(l));
         check({tag, " ack_bit"}, 32'(ack_bit), 32'(b));
      end
      @(negedge clk); ack = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset(); #2;
      check("R1 pend after reset", 32'(irq_pend), 0);
      @(negedge clk); try_ack("R1", 1'b0, 3'd0, 5'd0);

      for (int i = 0; i < NV; i++) begin
         do_reset();
         cur_pri = 3'd0; single_bus = 1'b0;
         post(VT[i].la, VT[i].ma);
         post(VT[i].lb, VT[i].mb);
         cur_pri = VT[i].pri; single_bus = VT[i].sb; #2;
         check($sformatf("R3 R4 R5 R6 R7 vec%0d pend", i), 32'(irq_pend), 32'(VT[i].pend));
         @(negedge clk);
         try_ack($sformatf("R4 R5 R6 R7 vec%0d", i), VT[i].pend, VT[i].el, VT[i].eb);
      end

      // R8: successive acks drain a level lowest bit first
      do_reset(); cur_pri = 3'd0; single_bus = 1'b0;
      post(5, 32'h3);
      try_ack("R8 first", 1'b1, 3'd5, 5'd0);
      try_ack("R8 second", 1'b1, 3'd5, 5'd1);
      try_ack("R8 drained", 1'b0, 3'd0, 5'd0);
      #2; check("R8 pend drained", 32'(irq_pend), 0);

      // R9: empty ack leaves hidden request untouched
      do_reset(); cur_pri = 3'd3;
      post(3, 32'h1);
      try_ack("R9 empty", 1'b0, 3'd0, 5'd0);
      cur_pri = 3'd0; #2;
      check("R9 pend revealed", 32'(irq_pend), 1);
      try_ack("R9 kept", 1'b1, 3'd3, 5'd0);

      // R10: set and clear of the same bit in one cycle
      do_reset(); cur_pri = 3'd0;
      post(5, 32'h1);
      set_stb[5] = 1'b1; set_mask[5*32 +: 32] = 32'h1;
      try_ack("R10 ack", 1'b1, 3'd5, 5'd0);
      set_stb = '0; set_mask = '0; #2;
      check("R10 pend kept", 32'(irq_pend), 1);
      try_ack("R10 still set", 1'b1, 3'd5, 5'd0);
      try_ack("R10 now empty", 1'b0, 3'd0, 5'd0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule